// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Pin Direction Control

This block is one general-purpose I/O port of a small microcontroller. Each pin has an output data latch and a direction bit, and the processor writes both through a simple register interface. A direction bit of 1 makes the pin an input: its driver is released and an optional pull-up may be enabled. A direction bit of 0 makes the pin a push-pull output that drives the latch value. The port occupies two adjacent addresses. The data register sits at an even base address and the direction register sits at the next odd address.

A read of the data address returns a mixed word. Input bits show the live pad level after a two-flop synchronizer, and output bits show the latch contents. Reads are combinational and not captured in any holding register. Single-bit set and clear operations read the selected register, force one bit and write the whole word back. Because output bits are read back from the latch, such an operation cannot corrupt the values being driven. Input bits of the latch, however, take whatever level the pad currently shows.

Top module: `gpio_port`

## Requirements
- R1: After reset every latch bit is 1, every direction bit is 1, every pad_oe bit is 0 and the direction register reads back all ones.
- R2: For each pin, pad_oe is 1 exactly when its direction bit is 0, and pad_out always equals the latch contents.
- R3: A read of the data address returns, per bit, the synchronized pad level when the direction bit is 1 and the latch bit when it is 0. A pad change becomes visible on the second rising clock edge after it occurs, not on the first.
- R4: A full write (bus_wr) to the data address loads bus_wdata into the latch on that clock edge, whatever the direction bits are. The latch keeps its value in every cycle that has no operation aimed at the data address.
- R5: The data register is at BASE_ADDR (even) and the direction register at BASE_ADDR+1. A read of the direction address returns the direction bits, a read of any other address returns 0, and writes to other addresses change nothing.
- R6: A bit set (bus_bset) or bit clear (bus_bclr) at the data address loads the latch with the current data-address read value, with bit bus_bitsel forced to 1 or 0.
- R7: A bit set or bit clear at the direction address forces direction bit bus_bitsel to 1 or 0 and leaves the other direction bits and the latch unchanged. A full write there loads the whole direction register.
- R8: pad_pull_en equals pad_pullup_cfg AND the direction bits, so the pull-up is enabled only on input pins.
- R9: When several strobes arrive in the same cycle, bus_wr wins over bus_bset, and bus_bset wins over bus_bclr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Full-word write strobe |
| bus_bset | input | 1 | Single-bit set strobe |
| bus_bclr | input | 1 | Single-bit clear strobe |
| bus_bitsel | input | BIT_W | Bit index for set/clear |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data |
| pad_in | input | WIDTH | Pad input levels |
| pad_pullup_cfg | input | WIDTH | Per-pin pull-up option |
| pad_out | output | WIDTH | Pad output data |
| pad_oe | output | WIDTH | Pad driver enable, 1 = drive |
| pad_pull_en | output | WIDTH | Pull-up enable per pin |

## Verification
The bench sweeps all 256 direction patterns. For each pattern the latch value and the pad value are chosen so that every bit position differs between them, so each read shows whether a bit came from the pad or from the latch. Bit set and clear are tried at every bit index on both registers, under a mixed direction pattern. Those results show that input bits of the latch pick up the pad level while output bits keep their latch values. A further pad toggle, read after one edge and after two, checks the synchronizer depth. Simultaneous strobes and an off-map address check the priority order and the address decode.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        GP_OP_NONE  = 2'd0,
        GP_OP_WRITE = 2'd1,
        GP_OP_SET   = 2'd2,
        GP_OP_CLR   = 2'd3
    } gp_op_e;

    // Strobe priority: full write, then set, then clear
    function automatic gp_op_e gp_pick_op(input logic wr, input logic bset, input logic bclr);
        if (wr)        return GP_OP_WRITE;
        else if (bset) return GP_OP_SET;
        else if (bclr) return GP_OP_CLR;
        else           return GP_OP_NONE;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{meta: '0, stable: '0};
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] pad_sync,
    input  logic             hit_data,
    input  logic             hit_ctrl,
    output logic [WIDTH-1:0] port_val,
    output logic [WIDTH-1:0] rdata
);
    // Per-bit source choice: input pins show the pad, output pins the latch
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign port_val[b] = dir[b] ? pad_sync[b] : latch[b];
    end

    always_comb begin
        if (hit_data)      rdata = port_val;
        else if (hit_ctrl) rdata = dir;
        else               rdata = '0;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int BIT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_data,
    input  logic             hit_ctrl,
    input  gp_op_e           op,
    input  logic [BIT_W-1:0] bitsel,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] port_val,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hit_data) begin
            unique case (op)
                GP_OP_WRITE: r_d.latch = wdata;
                GP_OP_SET: begin
                    r_d.latch         = port_val;
                    r_d.latch[bitsel] = 1'b1;
                end
                GP_OP_CLR: begin
                    r_d.latch         = port_val;
                    r_d.latch[bitsel] = 1'b0;
                end
                default: ;
            endcase
        end else if (hit_ctrl) begin
            unique case (op)
                GP_OP_WRITE: r_d.dir = wdata;
                GP_OP_SET:   r_d.dir[bitsel] = 1'b1;
                GP_OP_CLR:   r_d.dir[bitsel] = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{latch: '1, dir: '1};
        else        r_q <= r_d;
    end

    assign latch_q = r_q.latch;
    assign dir_q   = r_q.dir;

    assert_wr_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && op == GP_OP_WRITE) |=> latch_q == $past(wdata));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_data || op == GP_OP_NONE) |=> $stable(latch_q));

    assert_bset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && op == GP_OP_SET) |=> latch_q[$past(bitsel)] == 1'b1);

    assert_bclr_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctrl && op == GP_OP_CLR) |=> dir_q[$past(bitsel)] == 1'b0);

    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_ctrl || op == GP_OP_NONE) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 2,
    parameter int BIT_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_bset,
    input  logic              bus_bclr,
    input  logic [BIT_W-1:0]  bus_bitsel,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    input  logic [WIDTH-1:0]  pad_pullup_cfg,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pull_en
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE_ADDR + 1);

    logic             hit_data, hit_ctrl;
    gp_op_e           op;
    logic [WIDTH-1:0] pad_sync, port_val, latch_q, dir_q;

    assign hit_data = (bus_addr == DATA_ADDR);
    assign hit_ctrl = (bus_addr == CTRL_ADDR);
    assign op       = gp_pick_op(bus_wr, bus_bset, bus_bclr);

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .dir      (dir_q),
        .latch    (latch_q),
        .pad_sync (pad_sync),
        .hit_data (hit_data),
        .hit_ctrl (hit_ctrl),
        .port_val (port_val),
        .rdata    (bus_rdata)
    );

    gpio_regs #(.WIDTH(WIDTH), .BIT_W(BIT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_data (hit_data),
        .hit_ctrl (hit_ctrl),
        .op       (op),
        .bitsel   (bus_bitsel),
        .wdata    (bus_wdata),
        .port_val (port_val),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    assign pad_out     = latch_q;
    assign pad_oe      = ~dir_q;
    assign pad_pull_en = pad_pullup_cfg & dir_q;

    assert_wr_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && bus_wr) |=> pad_out == $past(bus_wdata));

    assert_ctrl_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |-> bus_rdata == ~pad_oe);
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int W = 8;
    localparam logic [3:0] A_DATA = 4'h2;
    localparam logic [3:0] A_CTRL = 4'h3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic         bus_wr = 1'b0, bus_bset = 1'b0, bus_bclr = 1'b0;
    logic [2:0]   bus_bitsel = '0;
    logic [W-1:0] bus_wdata = '0, bus_rdata;
    logic [W-1:0] pad_in = '0, pad_pullup_cfg = 8'h5A;
    logic [W-1:0] pad_out, pad_oe, pad_pull_en;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    logic [W-1:0] m_latch, m_dir, m_pad, m_rd;

    always #10 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_bset(bus_bset), .bus_bclr(bus_bclr), .bus_bitsel(bus_bitsel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_pullup_cfg(pad_pullup_cfg), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle: strobes set at a falling edge, taken at the next rising edge
    task automatic bus_op(input logic [3:0] a, input logic w, input logic s, input logic c,
                          input logic [2:0] b, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_bset = s; bus_bclr = c; bus_bitsel = b; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_bset = 1'b0; bus_bclr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #2 v = bus_rdata;
    endtask

    task automatic settle_pad(input logic [W-1:0] p);
        @(negedge clk);
        pad_in = p; m_pad = p;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state (checked with reset still active)
        chk("R1 latch", pad_out, 8'hFF);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R8 pull at reset", pad_pull_en, 8'h5A);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CTRL, m_rd); chk("R1 dir read", m_rd, 8'hFF);
        m_latch = 8'hFF; m_dir = 8'hFF;

        // R2 R3 R4 R8: sweep every direction pattern
        for (int d = 0; d < 256; d++) begin
            m_dir = 8'(d);
            m_latch = 8'(d) ^ 8'h3C;
            pad_pullup_cfg = 8'(d * 7 + 1);
            bus_op(A_CTRL, 1, 0, 0, 0, m_dir);
            bus_op(A_DATA, 1, 0, 0, 0, m_latch);
            settle_pad(~m_latch);
            rd(A_DATA, m_rd);
            chk("R3 mixed read", m_rd, (m_dir & m_pad) | (~m_dir & m_latch));
            chk("R2 oe", pad_oe, ~m_dir);
            chk("R4 latch any dir", pad_out, m_latch);
            chk("R8 pull", pad_pull_en, pad_pullup_cfg & m_dir);
        end

        // R6 R7: bit operations at every index
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < 2; s++) begin
                m_dir = 8'hF0; m_latch = 8'h96;
                bus_op(A_CTRL, 1, 0, 0, 0, m_dir);
                bus_op(A_DATA, 1, 0, 0, 0, m_latch);
                settle_pad(8'hA5);
                m_latch = (m_dir & m_pad) | (~m_dir & m_latch);
                m_latch[b] = (s == 0);
                bus_op(A_DATA, 0, s == 0, s == 1, 3'(b), 8'h00);
                chk("R6 data bit op", pad_out, m_latch);
                m_dir[b] = (s == 0);
                bus_op(A_CTRL, 0, s == 0, s == 1, 3'(b), 8'h00);
                rd(A_CTRL, m_rd);
                chk("R7 dir bit op", m_rd, m_dir);
                chk("R7 latch kept", pad_out, m_latch);
            end
        end

        // R3 synchronizer depth
        bus_op(A_CTRL, 1, 0, 0, 0, 8'hFF);
        settle_pad(8'h00);
        @(negedge clk); pad_in = 8'hC3;
        @(posedge clk); #1; rd(A_DATA, m_rd);
        chk("R3 one edge old", m_rd, 8'h00);
        @(posedge clk); #1; rd(A_DATA, m_rd);
        chk("R3 two edges new", m_rd, 8'hC3);

        // R9 priority
        bus_op(A_CTRL, 1, 0, 0, 0, 8'h00);
        bus_op(A_DATA, 1, 0, 0, 0, 8'hF0);
        bus_op(A_DATA, 1, 1, 1, 3'd2, 8'h11);
        chk("R9 write wins", pad_out, 8'h11);
        bus_op(A_DATA, 0, 1, 1, 3'd2, 8'h00);
        chk("R9 set over clear", pad_out, 8'h15);

        // R5 decode
        bus_op(4'h4, 1, 0, 0, 0, 8'h00);
        bus_op(4'h4, 0, 0, 1, 3'd0, 8'h00);
        chk("R5 other addr no write", pad_out, 8'h15);
        rd(4'h4, m_rd); chk("R5 other addr reads 0", m_rd, 8'h00);
        rd(A_CTRL, m_rd); chk("R5 ctrl read", m_rd, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule